// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host end of a clocked serial link to a converter. It produces the serial clock and an optional chip select. It turns single-word commands from the local user into framed transfers. A frame is a command byte followed by a data phase that either writes or reads. The block can also poll whether a conversion result is ready, and it can run a recovery pattern that puts a slave with lost framing back into a known state.

The data wires can be used in two ways, chosen by `sharedMode`. They can be separate output and input lines, or one bidirectional line. With one line, the host drives it only while it is sending and releases it during every read phase.

The recovery pattern depends on the wiring. With separate lines it is a long run of ones. With one shared line it is a dummy read first, then the run of ones. After recovery the slave's settings can no longer be trusted, so a flag asks the user to program them again. Bit timing comes from a divider parameter. The user issues commands through a valid strobe and gets back a one-cycle completion pulse.

Top module: `serLinkHost`

## Requirements
- R1: After reset, `sclk`=1, `csN`=1, `busy`=0, `rspValid`=0, `convReady`=0 and `reconfigNeeded`=0.
- R2: `sclk` is high whenever `busy` is low. Within a frame every `sclk` level lasts exactly DIV system clocks. A write or read frame has 8+N rising edges.
- R3: Write (`cmdOp`=0) sends `cmdComm` and then the N low bits of `cmdWdata`, both MSB first. N is set by `cmdLen`: 1→8, 2→16, 3→24, 0→8. Each bit is valid on `dout` at the rising `sclk` edge.
- R4: Read (`cmdOp`=1) sends `cmdComm` and then samples N bits of `din` on rising edges, MSB first. `dout` is held at 1 during the read phase. `rspData` returns the bits right-aligned and zero-extended.
- R5: Poll (`cmdOp`=2) sends `cmdComm` and reads 8 bits. `convReady` becomes the inverse of the MSB of the received byte and holds until the next poll.
- R6: Resync (`cmdOp`=3) with separate lines gives ONES_BITS (default 32) rising edges with `dout`=1 and `doutOe`=1.
- R7: Resync on a shared line gives DUMMY_BITS (default 24) released read edges, then ONES_BITS edges that drive ones. `rspData` is not changed.
- R8: On a shared line, `doutOe` is 0 on every read-phase edge and while idle, and 1 on every driven edge. With separate lines, `doutOe` stays 1.
- R9: `reconfigNeeded` is set when a resync completes. Reads and polls leave it set. It is cleared when a write command is accepted.
- R10: `busy` rises the cycle after a command is accepted. Any `cmdValid` while `busy` is high is ignored.
- R11: With `useCs`=1, `csN` is low for the whole frame and high when idle. With `useCs`=0, `csN` stays low.
- R12: `rspValid` is a one-cycle pulse in the cycle `busy` falls, one half period after the last rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sharedMode | input | 1 | 1: one bidirectional data line; 0: separate lines |
| useCs | input | 1 | 1: frame with `csN`; 0: `csN` held low |
| cmdValid | input | 1 | Command strobe, taken when idle |
| cmdOp | input | 2 | 0 write, 1 read, 2 poll, 3 resync |
| cmdLen | input | 2 | Data phase length code (1/2/3 → 8/16/24, 0 → 8) |
| cmdComm | input | 8 | Command byte sent first |
| cmdWdata | input | 24 | Write data, right-aligned |
| busy | output | 1 | Transfer in progress |
| rspValid | output | 1 | Completion pulse |
| rspData | output | 24 | Last read word, right-aligned |
| convReady | output | 1 | Result-ready status from last poll |
| reconfigNeeded | output | 1 | Slave settings must be rewritten |
| sclk | output | 1 | Serial clock, idles high |
| csN | output | 1 | Active-low chip select |
| dout | output | 1 | Host data toward slave |
| doutOe | output | 1 | Drive enable for `dout` |
| din | input | 1 | Data from slave (resolved line in shared mode) |

## Verification
Two events can land in the same system cycle. One is the last rising edge of one phase, which samples `din` and ends that phase. The other is the load of the next phase, which reloads the bit counter and may clear the receive register. The shared-line resync forces this with a read phase followed by a ones phase. Command plus read forces it the other way, with a write phase followed by a read phase. The bench judges the result by the exact edge count, by half periods that never stretch, and by the drive enable switching on the correct edge. A second collision is a command strobe landing while a transfer is running. The bench injects one mid-frame and checks that the frame's bits and edge count are unchanged.

// File: rtl/serLinkPkg.sv
package serLinkPkg;
  localparam int WORD_W = 24;
  localparam int CNT_W = 8;
  localparam int COMM_W = 8;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_READ   = 2'd1,
    OP_POLL   = 2'd2,
    OP_RESYNC = 2'd3
  } cmdOp_e;

  typedef enum logic [1:0] {
    PH_WRITE = 2'd0,
    PH_READ  = 2'd1,
    PH_ONES  = 2'd2
  } phaseKind_e;

  // one phase of a frame as chosen by the control
  typedef struct packed {
    logic              valid;
    phaseKind_e        kind;
    logic [CNT_W-1:0]  bits;
    logic [WORD_W-1:0] txVal;
  } phaseDesc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              run;
    logic              load;
    phaseKind_e        kind;
    logic [CNT_W-1:0]  bits;
    logic [WORD_W-1:0] txVal;
  } dpCtrl_t;

  function automatic logic [CNT_W-1:0] lenBits(input logic [1:0] code);
    case (code)
      2'd2:    lenBits = CNT_W'(16);
      2'd3:    lenBits = CNT_W'(24);
      default: lenBits = CNT_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/serLinkDatapath.sv
module serLinkDatapath
  import serLinkPkg::*;
#(
  parameter int DIV = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sharedMode,
  input  dpCtrl_t           ctrl,
  input  logic              din,
  output logic              tick,
  output logic              phaseEnd,
  output logic              sclk,
  output logic              dout,
  output logic              doutOe,
  output logic [WORD_W-1:0] rxWord
);
  localparam int DIV_W = (DIV < 2) ? 1 : $clog2(DIV);

  logic [DIV_W-1:0]  halfCnt;
  logic              sclkR, doutR, oeR;
  phaseKind_e        kindR;
  logic [CNT_W-1:0]  bitCnt;
  logic [WORD_W-1:0] txSh, rxSh;
  logic              fallNow, riseNow;

  assign tick     = ctrl.run && (halfCnt == DIV_W'(DIV - 1));
  assign fallNow  = tick && sclkR && (bitCnt != '0);
  assign riseNow  = tick && !sclkR;
  assign phaseEnd = riseNow && (bitCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
      sclkR   <= 1'b1;
      doutR   <= 1'b1;
      oeR     <= 1'b0;
      kindR   <= PH_WRITE;
      bitCnt  <= '0;
      txSh    <= '0;
      rxSh    <= '0;
    end else begin
      if (!ctrl.run || tick) halfCnt <= '0;
      else                   halfCnt <= halfCnt + 1'b1;

      if (!ctrl.run) begin
        doutR <= 1'b1;
        oeR   <= !sharedMode;
      end

      if (fallNow) begin
        sclkR <= 1'b0;
        case (kindR)
          PH_WRITE: begin
            doutR <= txSh[WORD_W-1];
            txSh  <= txSh << 1;
            oeR   <= 1'b1;
          end
          PH_READ: begin
            doutR <= 1'b1;
            oeR   <= !sharedMode;
          end
          default: begin
            doutR <= 1'b1;
            oeR   <= 1'b1;
          end
        endcase
      end

      if (riseNow) begin
        sclkR  <= 1'b1;
        bitCnt <= bitCnt - 1'b1;
        if (kindR == PH_READ) rxSh <= {rxSh[WORD_W-2:0], din};
      end

      if (ctrl.load) begin
        kindR  <= ctrl.kind;
        bitCnt <= ctrl.bits;
        txSh   <= ctrl.txVal;
        if (ctrl.kind == PH_READ) rxSh <= '0;
      end
    end
  end

  assign sclk   = sclkR;
  assign dout   = doutR;
  assign doutOe = oeR;
  assign rxWord = rxSh;
endmodule

// File: rtl/serLinkControl.sv
module serLinkControl
  import serLinkPkg::*;
#(
  parameter int ONES_BITS  = 32,
  parameter int DUMMY_BITS = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sharedMode,
  input  logic              useCs,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [1:0]        cmdLen,
  input  logic [COMM_W-1:0] cmdComm,
  input  logic [WORD_W-1:0] cmdWdata,
  input  logic              tick,
  input  logic              phaseEnd,
  input  logic [WORD_W-1:0] rxWord,
  output dpCtrl_t           ctrl,
  output logic              busy,
  output logic              csN,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspData,
  output logic              convReady,
  output logic              reconfigNeeded
);
  typedef enum logic [1:0] {S_IDLE, S_PH0, S_PH1, S_TRAIL} state_e;

  state_e            state;
  cmdOp_e            opR;
  logic [1:0]        lenR;
  logic [COMM_W-1:0] commR;
  logic [WORD_W-1:0] wdataR;
  logic              busyR, csNR, rspValidR, convReadyR, reconfR;
  logic [WORD_W-1:0] rspDataR;
  logic              accept;
  phaseDesc_t        ph0, ph1;

  function automatic phaseDesc_t pickPhase(
    input logic              second,
    input cmdOp_e            op,
    input logic              shared,
    input logic [COMM_W-1:0] comm,
    input logic [1:0]        len,
    input logic [WORD_W-1:0] wdata
  );
    phaseDesc_t p;
    logic [CNT_W-1:0] n;
    n = lenBits(len);
    p = '{valid: 1'b1, kind: PH_WRITE, bits: CNT_W'(COMM_W),
          txVal: {comm, {(WORD_W-COMM_W){1'b0}}}};
    if (op == OP_RESYNC) begin
      if (shared && !second) begin
        p.kind = PH_READ;
        p.bits = CNT_W'(DUMMY_BITS);
      end else if (shared || !second) begin
        p.kind = PH_ONES;
        p.bits = CNT_W'(ONES_BITS);
      end else begin
        p.valid = 1'b0;
      end
      p.txVal = '0;
    end else if (second) begin
      case (op)
        OP_WRITE: begin
          p.kind  = PH_WRITE;
          p.bits  = n;
          p.txVal = wdata << (WORD_W - int'(n));
        end
        OP_READ: begin
          p.kind  = PH_READ;
          p.bits  = n;
          p.txVal = '0;
        end
        default: begin
          p.kind  = PH_READ;
          p.bits  = CNT_W'(8);
          p.txVal = '0;
        end
      endcase
    end
    return p;
  endfunction

  assign accept = (state == S_IDLE) && cmdValid;
  assign ph0 = pickPhase(1'b0, cmdOp_e'(cmdOp), sharedMode, cmdComm, cmdLen, cmdWdata);
  assign ph1 = pickPhase(1'b1, opR, sharedMode, commR, lenR, wdataR);

  always_comb begin
    ctrl.run   = (state != S_IDLE);
    ctrl.load  = accept || ((state == S_PH0) && phaseEnd && ph1.valid);
    ctrl.kind  = accept ? ph0.kind  : ph1.kind;
    ctrl.bits  = accept ? ph0.bits  : ph1.bits;
    ctrl.txVal = accept ? ph0.txVal : ph1.txVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      opR        <= OP_WRITE;
      lenR       <= '0;
      commR      <= '0;
      wdataR     <= '0;
      busyR      <= 1'b0;
      csNR       <= 1'b1;
      rspValidR  <= 1'b0;
      rspDataR   <= '0;
      convReadyR <= 1'b0;
      reconfR    <= 1'b0;
    end else begin
      rspValidR <= 1'b0;
      case (state)
        S_IDLE: begin
          csNR <= useCs;
          if (accept) begin
            opR    <= cmdOp_e'(cmdOp);
            lenR   <= cmdLen;
            commR  <= cmdComm;
            wdataR <= cmdWdata;
            busyR  <= 1'b1;
            csNR   <= 1'b0;
            state  <= S_PH0;
            if (cmdOp_e'(cmdOp) == OP_WRITE) reconfR <= 1'b0;
          end
        end
        S_PH0: if (phaseEnd) state <= ph1.valid ? S_PH1 : S_TRAIL;
        S_PH1: if (phaseEnd) state <= S_TRAIL;
        default: begin
          if (tick) begin
            state     <= S_IDLE;
            busyR     <= 1'b0;
            rspValidR <= 1'b1;
            csNR      <= useCs;
            if (opR == OP_READ || opR == OP_POLL) rspDataR <= rxWord;
            if (opR == OP_POLL) convReadyR <= !rxWord[7];
            if (opR == OP_RESYNC) reconfR <= 1'b1;
          end
        end
      endcase
    end
  end

  assign busy           = busyR;
  assign csN            = csNR;
  assign rspValid       = rspValidR;
  assign rspData        = rspDataR;
  assign convReady      = convReadyR;
  assign reconfigNeeded = reconfR;
endmodule

// File: rtl/serLinkHost.sv
module serLinkHost #(
  parameter int DIV        = 4,
  parameter int ONES_BITS  = 32,
  parameter int DUMMY_BITS = 24
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sharedMode,
  input  logic        useCs,
  input  logic        cmdValid,
  input  logic [1:0]  cmdOp,
  input  logic [1:0]  cmdLen,
  input  logic [7:0]  cmdComm,
  input  logic [23:0] cmdWdata,
  output logic        busy,
  output logic        rspValid,
  output logic [23:0] rspData,
  output logic        convReady,
  output logic        reconfigNeeded,
  output logic        sclk,
  output logic        csN,
  output logic        dout,
  output logic        doutOe,
  input  logic        din
);
  serLinkPkg::dpCtrl_t ctrl;
  logic tick, phaseEnd;
  logic [serLinkPkg::WORD_W-1:0] rxWord;

  serLinkControl #(.ONES_BITS(ONES_BITS), .DUMMY_BITS(DUMMY_BITS)) ctl (
    .clk(clk), .rstN(rstN), .sharedMode(sharedMode), .useCs(useCs),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen), .cmdComm(cmdComm),
    .cmdWdata(cmdWdata), .tick(tick), .phaseEnd(phaseEnd), .rxWord(rxWord),
    .ctrl(ctrl), .busy(busy), .csN(csN), .rspValid(rspValid),
    .rspData(rspData), .convReady(convReady), .reconfigNeeded(reconfigNeeded)
  );

  serLinkDatapath #(.DIV(DIV)) dp (
    .clk(clk), .rstN(rstN), .sharedMode(sharedMode), .ctrl(ctrl), .din(din),
    .tick(tick), .phaseEnd(phaseEnd), .sclk(sclk), .dout(dout),
    .doutOe(doutOe), .rxWord(rxWord)
  );
endmodule

// File: rtl/serLinkHostChecker.sv
module serLinkHostChecker (
  input logic        clk,
  input logic        rstN,
  input logic        sharedMode,
  input logic        useCs,
  input logic        cmdValid,
  input logic [1:0]  cmdOp,
  input logic        busy,
  input logic        rspValid,
  input logic        reconfigNeeded,
  input logic        sclk,
  input logic        csN,
  input logic        doutOe
);
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclk);

  assert_cs_in_frame_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sclk |-> !csN);

  assert_cs_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(rstN) && $past(useCs)) |-> csN);

  assert_rsp_with_fall_R12: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> rspValid);

  assert_rsp_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!busy && $past(busy)));

  assert_oe_separate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sharedMode && $past(!sharedMode) && $past(rstN)) |-> doutOe);

  assert_reconfig_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reconfigNeeded) |-> $past(cmdValid && !busy && cmdOp == 2'd0));

  assert_busy_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);
endmodule

bind serLinkHost serLinkHostChecker chk (
  .clk(clk), .rstN(rstN), .sharedMode(sharedMode), .useCs(useCs),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy), .rspValid(rspValid),
  .reconfigNeeded(reconfigNeeded), .sclk(sclk), .csN(csN), .doutOe(doutOe)
);

// File: tb/tb_serLinkHost.sv
module tb_serLinkHost;
  localparam int DIV = 2, ONES = 32, DUMMY = 24;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, sharedMode, useCs, cmdValid;
  logic [1:0] cmdOp, cmdLen;
  logic [7:0] cmdComm;
  logic [23:0] cmdWdata, rspData;
  logic busy, rspValid, convReady, reconfigNeeded, sclk, csN, dout, doutOe, din;

  serLinkHost #(.DIV(DIV), .ONES_BITS(ONES), .DUMMY_BITS(DUMMY)) dut (
    .clk(clk), .rstN(rstN), .sharedMode(sharedMode), .useCs(useCs),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdLen(cmdLen), .cmdComm(cmdComm),
    .cmdWdata(cmdWdata), .busy(busy), .rspValid(rspValid), .rspData(rspData),
    .convReady(convReady), .reconfigNeeded(reconfigNeeded), .sclk(sclk),
    .csN(csN), .dout(dout), .doutOe(doutOe), .din(din)
  );

  // slave model and line resolution
  logic slaveVal, slaveEn;
  logic [63:0] slaveBits, slaveMask;
  assign din = (sharedMode && doutOe) ? dout : (slaveEn ? slaveVal : 1'b1);

  int nChecks = 0, nErr = 0, cyc = 0;
  int riseCnt, lastChg, gapErr, clashCnt;
  logic prevSclk = 1'b1;
  logic [63:0] capOut, capOe, capCs;
  bit wdFired = 0;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (sclk !== prevSclk) begin
        if (lastChg >= 0 && (cyc - lastChg) != DIV) gapErr++;
        lastChg = cyc;
        if (sclk) begin
          if (riseCnt < 64) begin
            capOut[riseCnt] = dout;
            capOe[riseCnt]  = doutOe;
            capCs[riseCnt]  = csN;
          end
          riseCnt++;
        end else if (riseCnt < 64) begin
          slaveVal = slaveBits[riseCnt];
          slaveEn  = slaveMask[riseCnt];
        end
      end
      if (sharedMode && doutOe && slaveEn) clashCnt++;
    end
    prevSclk = sclk;
    if (cyc > 150000 && !wdFired) begin
      wdFired = 1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog: run did not finish actual=%0d expected<=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic expReconf = 0, expReady = 0;
  logic [23:0] expRsp = 0;

  task automatic runOp(input logic [1:0] op, input logic [1:0] len, input logic [7:0] comm,
                       input logic [23:0] wdata, input logic [23:0] rdata, input bit poke);
    int n, idx, t;
    logic [63:0] expOut, expOe, allMask;
    string req;
    n = (len == 2'd0) ? 8 : 8 * int'(len);
    if (op == 2'd2) n = 8;
    idx = 0; expOut = '0; expOe = '0;
    slaveBits = '0; slaveMask = '0;
    req = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R4" : (op == 2'd2) ? "R5" :
          (sharedMode ? "R7" : "R6");
    if (op != 2'd3) begin
      for (int i = 0; i < 8; i++) begin
        expOut[idx] = comm[7-i]; expOe[idx] = 1'b1; idx++;
      end
      for (int i = 0; i < n; i++) begin
        if (op == 2'd0) begin
          expOut[idx] = wdata[n-1-i]; expOe[idx] = 1'b1;
        end else begin
          expOut[idx] = 1'b1; expOe[idx] = !sharedMode;
          slaveMask[idx] = 1'b1; slaveBits[idx] = rdata[n-1-i];
        end
        idx++;
      end
    end else begin
      if (sharedMode) begin
        for (int i = 0; i < DUMMY; i++) begin
          expOut[idx] = 1'b1; expOe[idx] = 1'b0;
          slaveMask[idx] = 1'b1; slaveBits[idx] = rdata[i % 24]; idx++;
        end
      end
      for (int i = 0; i < ONES; i++) begin
        expOut[idx] = 1'b1; expOe[idx] = 1'b1; idx++;
      end
    end
    allMask = (idx >= 64) ? '1 : ((64'd1 << idx) - 1);

    riseCnt = 0; lastChg = -1; gapErr = 0; clashCnt = 0; slaveEn = 0;
    capOut = '0; capOe = '0; capCs = '0;

    @(negedge clk);
    cmdValid = 1; cmdOp = op; cmdLen = len; cmdComm = comm; cmdWdata = wdata;
    @(negedge clk);
    cmdValid = 0;
    chk("R10", "busy after accept", busy, 1);
    if (poke) begin
      repeat (7) @(negedge clk);
      cmdValid = 1; cmdOp = 2'd3; cmdComm = ~comm; cmdWdata = ~wdata;
      @(negedge clk);
      cmdValid = 0;
    end
    t = 0;
    while (!rspValid && t < 5000) begin @(negedge clk); t++; end
    chk("R12", "rspValid seen", rspValid, 1);
    chk("R12", "busy low with rspValid", busy, 0);
    chk(req, "rising edge count", riseCnt, idx);
    chk(req, "dout bits", capOut & allMask, expOut);
    chk("R8", "doutOe per edge", capOe & allMask, expOe);
    chk("R8", "line contention", clashCnt, 0);
    chk("R2", "half period violations", gapErr, 0);
    chk("R11", "csN in frame", capCs & allMask, 0);
    if (poke) chk("R10", "ignored command left frame intact", riseCnt, idx);
    if (op == 2'd1 || op == 2'd2) expRsp = rdata & ((24'd1 << n) - 1);
    if (op == 2'd2) expReady = !rdata[7];
    if (op == 2'd3) expReconf = 1;
    if (op == 2'd0) expReconf = 0;
    chk(req, "rspData", rspData, expRsp);
    chk("R5", "convReady", convReady, expReady);
    chk("R9", "reconfigNeeded", reconfigNeeded, expReconf);
    @(negedge clk);
    chk("R12", "rspValid single pulse", rspValid, 0);
    chk("R11", "csN idle level", csN, useCs);
    chk("R2", "sclk idle high", sclk, 1);
    chk("R8", "doutOe idle", doutOe, !sharedMode);
  endtask

  initial begin
    rstN = 0; sharedMode = 0; useCs = 1; cmdValid = 0;
    cmdOp = 0; cmdLen = 0; cmdComm = 0; cmdWdata = 0;
    slaveEn = 0; slaveVal = 1; slaveBits = '0; slaveMask = '0;
    riseCnt = 0; lastChg = -1; gapErr = 0; clashCnt = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "sclk", sclk, 1);
    chk("R1", "csN", csN, 1);
    chk("R1", "busy", busy, 0);
    chk("R1", "rspValid", rspValid, 0);
    chk("R1", "convReady", convReady, 0);
    chk("R1", "reconfigNeeded", reconfigNeeded, 0);

    for (int mode = 0; mode < 4; mode++) begin
      int k;
      sharedMode = mode[1];
      useCs = mode[0];
      repeat (3) @(negedge clk);
      k = mode * 16;
      runOp(2'd3, 2'd0, 8'h00, 24'h0, 24'h9B5E17 + k, 0);
      for (int ln = 0; ln < 4; ln++) begin
        runOp(2'd1, ln[1:0], 8'h38 + 8'(ln), 24'h0,
              24'hC3A51F + 24'(k + ln) * 24'h111111, 0);
      end
      runOp(2'd2, 2'd1, 8'h08, 24'h0, 24'h00005A, 0);
      runOp(2'd2, 2'd1, 8'h08, 24'h0, 24'h0000D6 + 24'(k), 0);
      for (int ln = 0; ln < 4; ln++) begin
        runOp(2'd0, ln[1:0], 8'h10 + 8'(ln),
              24'h5A3C96 ^ (24'(k + ln) * 24'h0F1E2D), 24'h0, ln == 3);
      end
      runOp(2'd1, 2'd2, 8'h58, 24'h0, 24'h00F00F ^ 24'(k), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErr);
    $finish;
  end
endmodule